// File: doc/BRIEF.md
# Stop-Release Busy Mask Sequencer

This block is glue logic placed beside a bus arbiter. It hides a fault that lets arbiters lose step with each other when the global stop is released. The block watches a delayed copy of the global stop. Once that copy has been seen, it waits for a cycle in which the shared busy line is idle. It then holds busy asserted for a fixed minimum number of cycles, and keeps holding it until stop has cleared, whichever comes later. The arbiters resume only after all of them have settled.

The block also drives the active-low stop-active line and the active-low bus-busy line. Stop-active follows an external force-stop request or any non-idle sequencer state. Bus-busy is held low while stop-active is asserted and for a short tail after it. A mask-enable input selects between the full workaround and a bypass. In the bypass, the sequencer only tracks stop and never raises busy. For a fixed startup window after reset, the sequencer is held idle so that the pipelines can fill.

Top module: `stop_busy_mask`

## Requirements
- R1: While rst_ni is low, and with force_stop_i and force_busy_i low, stop_act_no, busy_no and bus_busy_no are all high and the sequencer is idle.
- R2: For the first 2*PIPE_DEPTH (20) clock edges after reset is released, the sequencer stays idle whatever the stop input does. During that window stop_act_no is the inverse of force_stop_i.
- R3: glob_stop_i is delayed by STOP_DLY (3) clock edges. From idle, the sequencer arms on an edge at which the delayed stop is high.
- R4: When armed with mask_en_i high, the sequencer leaves the armed state on the first edge at which busy_ni is high (idle). While busy_ni is low, it stays armed.
- R5: After leaving the armed state, the sequencer passes through one gap state and then HOLD_MIN (5) hold states, one per clock, whatever stop, busy_ni or mask_en_i do. busy_no is low in every hold state.
- R6: After the hold states, the sequencer waits with busy_no low. It returns to idle on the first edge at which the delayed stop is low.
- R7: When armed with mask_en_i low, the sequencer returns to idle on an edge at which the delayed stop is low, stays armed otherwise, and never drives busy_no low.
- R8: stop_act_no is low exactly when force_stop_i is high or the sequencer is not idle. The force term is combinational.
- R9: busy_no is low exactly when the sequencer is in a hold state or in the wait state, which means any state past the gap.
- R10: bus_busy_no is low when force_busy_i is high, in every cycle in which stop-active is asserted, and in the BB_HOLD-1 (5) cycles after the last such cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_stop_i | input | 1 | Global stop, active high, before the internal delay |
| busy_ni | input | 1 | Shared busy line as seen by this block, active low |
| force_stop_i | input | 1 | External request to assert stop-active |
| force_busy_i | input | 1 | External request to assert bus-busy |
| mask_en_i | input | 1 | 1 = full workaround, 0 = bypass (no busy hold) |
| stop_act_no | output | 1 | Stop-active, active low |
| busy_no | output | 1 | Busy output, active low |
| bus_busy_no | output | 1 | Bus-busy, active low |

## Verification
The interesting collisions happen at the end of the wait state. In the same edge, the delayed stop can fall while the sequencer leaves the wait state, and the bus-busy tail is restarted by the last stop-active cycle. There is also the case where force-stop overlaps a non-idle state, so that two sources drive stop-active at once. Directed phases line up a stop release with the final hold state, and hold stop across the wait state and then drop it. A long random phase toggles stop, busy and the force inputs independently. Every cycle, all three outputs are compared with a behavioural reference that tracks the stop history in a queue and the last stop-active cycle as an integer.

// File: rtl/stop_busy_mask_pkg.sv
package stop_busy_mask_pkg;
  // fixed low state codes; hold and wait codes derive from HOLD_MIN
  localparam int unsigned ST_IDLE = 0;
  localparam int unsigned ST_ARM  = 1;
  localparam int unsigned ST_GAP  = 2;

  function automatic int unsigned seq_last(input int unsigned hold_min);
    return ST_GAP + hold_min + 1;
  endfunction

  function automatic int unsigned seq_width(input int unsigned hold_min);
    return $clog2(seq_last(hold_min) + 1);
  endfunction
endpackage

// File: rtl/stop_busy_mask_dly.sv
module stop_busy_mask_dly #(
  parameter int unsigned DLY = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  generate
    if (DLY == 0) begin : g_pass
      assign q_o = d_i;
    end else if (DLY == 1) begin : g_one
      logic q_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q_q <= 1'b0;
        else         q_q <= d_i;
      end
      assign q_o = q_q;
    end else begin : g_line
      logic [DLY-1:0] sr_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[DLY-2:0], d_i};
      end
      assign q_o = sr_q[DLY-1];
    end
  endgenerate
endmodule

// File: rtl/stop_busy_mask_warm.sv
module stop_busy_mask_warm #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == LIM);
endmodule

// File: rtl/stop_busy_mask_seq.sv
module stop_busy_mask_seq
  import stop_busy_mask_pkg::*;
#(
  parameter int unsigned HOLD_MIN = 5,
  localparam int unsigned SW = seq_width(HOLD_MIN)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          warm_i,
  input  logic          stop_d_i,
  input  logic          busy_idle_i,
  input  logic          mask_en_i,
  output logic [SW-1:0] st_o
);
  localparam logic [SW-1:0] S_IDLE = SW'(ST_IDLE);
  localparam logic [SW-1:0] S_ARM  = SW'(ST_ARM);
  localparam logic [SW-1:0] S_GAP  = SW'(ST_GAP);
  localparam logic [SW-1:0] S_LAST = SW'(seq_last(HOLD_MIN));

  logic [SW-1:0] st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!warm_i) begin
      st_d = S_IDLE;
    end else if (st_q == S_IDLE) begin
      if (stop_d_i) st_d = S_ARM;
    end else if (st_q == S_ARM) begin
      if (mask_en_i) begin
        if (busy_idle_i) st_d = S_GAP;
      end else if (!stop_d_i) begin
        st_d = S_IDLE;
      end
    end else if (st_q == S_LAST) begin
      if (!stop_d_i) st_d = S_IDLE;
    end else if (st_q > S_LAST) begin
      st_d = S_IDLE;
    end else begin
      // gap and hold states run unconditionally
      st_d = st_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= S_IDLE;
    else         st_q <= st_d;
  end

  assign st_o = st_q;
endmodule

// File: rtl/stop_busy_mask_tmr.sv
module stop_busy_mask_tmr #(
  parameter int unsigned HOLD = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic active_o
);
  generate
    if (HOLD <= 1) begin : g_none
      assign active_o = trig_i;
    end else begin : g_cnt
      localparam int unsigned CW = $clog2(HOLD);
      localparam logic [CW-1:0] TAIL = CW'(HOLD - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)            cnt_q <= '0;
        else if (trig_i)        cnt_q <= TAIL;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign active_o = trig_i | (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/stop_busy_mask.sv
module stop_busy_mask
  import stop_busy_mask_pkg::*;
#(
  parameter int unsigned PIPE_DEPTH = 10,
  parameter int unsigned STOP_DLY   = 3,
  parameter int unsigned HOLD_MIN   = 5,
  parameter int unsigned BB_HOLD    = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic glob_stop_i,
  input  logic busy_ni,
  input  logic force_stop_i,
  input  logic force_busy_i,
  input  logic mask_en_i,
  output logic stop_act_no,
  output logic busy_no,
  output logic bus_busy_no
);
  localparam int unsigned STARTUP = 2 * PIPE_DEPTH;
  localparam int unsigned SW = seq_width(HOLD_MIN);
  localparam logic [SW-1:0] S_GAP = SW'(ST_GAP);

  logic          stop_d;
  logic          warm;
  logic [SW-1:0] st;
  logic          stop_act;
  logic          bb_act;

  stop_busy_mask_dly #(.DLY(STOP_DLY)) u_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (glob_stop_i),
    .q_o   (stop_d)
  );

  stop_busy_mask_warm #(.LIMIT(STARTUP)) u_warm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .done_o(warm)
  );

  stop_busy_mask_seq #(.HOLD_MIN(HOLD_MIN)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .warm_i     (warm),
    .stop_d_i   (stop_d),
    .busy_idle_i(busy_ni),
    .mask_en_i  (mask_en_i),
    .st_o       (st)
  );

  assign stop_act = force_stop_i | (st != '0);

  stop_busy_mask_tmr #(.HOLD(BB_HOLD)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .trig_i  (stop_act),
    .active_o(bb_act)
  );

  assign stop_act_no = ~stop_act;
  assign busy_no     = ~(st > S_GAP);
  assign bus_busy_no = ~(force_busy_i | bb_act);
endmodule

// File: rtl/stop_busy_mask_chk.sv
module stop_busy_mask_chk #(
  parameter int unsigned HOLD_MIN = 5,
  parameter int unsigned STARTUP  = 20,
  parameter int unsigned BB_HOLD  = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic force_stop_i,
  input logic stop_act_no,
  input logic busy_no,
  input logic bus_busy_no
);
  localparam int unsigned WW = $clog2(STARTUP + 2);
  localparam int unsigned RW = $clog2(HOLD_MIN + 2);
  localparam logic [WW-1:0] WSAT = WW'(STARTUP + 1);
  localparam logic [RW-1:0] RSAT = RW'(HOLD_MIN + 1);

  logic [WW-1:0] edges_q;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q <= '0;
      run_q   <= '0;
    end else begin
      if (edges_q != WSAT) edges_q <= edges_q + 1'b1;
      if (busy_no)              run_q <= '0;
      else if (run_q != RSAT)   run_q <= run_q + 1'b1;
    end
  end

  // R8
  force_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_stop_i |-> !stop_act_no);

  // R9
  busy_in_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> !stop_act_no);

  // R10
  bb_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_act_no |-> !bus_busy_no);

  // R10
  bb_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (BB_HOLD > 1) && $rose(stop_act_no) |-> !bus_busy_no);

  // R5
  hold_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_no) |-> (run_q >= RW'(HOLD_MIN)));

  // R2
  startup_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q <= WW'(STARTUP)) |-> (stop_act_no == !force_stop_i) && busy_no);
endmodule

bind stop_busy_mask stop_busy_mask_chk #(
  .HOLD_MIN(HOLD_MIN),
  .STARTUP (2 * PIPE_DEPTH),
  .BB_HOLD (BB_HOLD)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .force_stop_i(force_stop_i),
  .stop_act_no (stop_act_no),
  .busy_no     (busy_no),
  .bus_busy_no (bus_busy_no)
);

// File: tb/stop_busy_mask_tb.sv
module stop_busy_mask_tb;
  localparam int PIPE_DEPTH = 10;
  localparam int STOP_DLY   = 3;
  localparam int HOLD_MIN   = 5;
  localparam int BB_HOLD    = 6;
  localparam int STARTUP    = 2 * PIPE_DEPTH;
  localparam int LAST_ST    = HOLD_MIN + 3;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic glob_stop_i = 1'b0, busy_ni = 1'b1, force_stop_i = 1'b0;
  logic force_busy_i = 1'b0, mask_en_i = 1'b1;
  logic stop_act_no, busy_no, bus_busy_no;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  // reference state
  int m_st, m_cyc, m_last_sa;
  bit m_q[$];

  always #10 clk_i = ~clk_i;

  stop_busy_mask #(.PIPE_DEPTH(PIPE_DEPTH), .STOP_DLY(STOP_DLY),
                   .HOLD_MIN(HOLD_MIN), .BB_HOLD(BB_HOLD)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .glob_stop_i(glob_stop_i), .busy_ni(busy_ni),
    .force_stop_i(force_stop_i), .force_busy_i(force_busy_i), .mask_en_i(mask_en_i),
    .stop_act_no(stop_act_no), .busy_no(busy_no), .bus_busy_no(bus_busy_no)
  );

  task automatic cmp(input logic act, input logic exp, input string what, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s cyc=%0d got=%b exp=%b", tag, what, m_cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_st = 0; m_cyc = 0; m_last_sa = -1000;
    m_q.delete();
    for (int i = 0; i < STOP_DLY; i++) m_q.push_back(1'b0);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk_i);
    rst_ni = 1'b0; force_stop_i = 1'b0; force_busy_i = 1'b0;
    #2;
    // R1 outputs idle under reset
    cmp(stop_act_no, 1'b1, "stop_act_no reset R1", tag);
    cmp(busy_no,     1'b1, "busy_no reset R1", tag);
    cmp(bus_busy_no, 1'b1, "bus_busy_no reset R1", tag);
    @(negedge clk_i);
    model_reset();
    rst_ni = 1'b1;
  endtask

  task automatic step(input bit gs, input bit fs, input bit fb, input bit bi,
                      input bit me, input string tag);
    bit sd, sa, warm;
    int nx;
    glob_stop_i = gs; force_stop_i = fs; force_busy_i = fb; busy_ni = bi; mask_en_i = me;
    #2;
    sd = m_q[0];
    sa = fs || (m_st != 0);
    if (sa) m_last_sa = m_cyc;
    cmp(stop_act_no, !sa, "stop_act_no R8", tag);
    cmp(busy_no, !(m_st > 2), "busy_no R9", tag);
    cmp(bus_busy_no, !(fb || (m_cyc - m_last_sa < BB_HOLD)), "bus_busy_no R10", tag);
    warm = (m_cyc >= STARTUP);
    if (!warm) nx = 0;
    else if (m_st == 0) nx = sd ? 1 : 0;
    else if (m_st == 1) nx = me ? (bi ? 2 : 1) : (sd ? 1 : 0);
    else if (m_st == LAST_ST) nx = sd ? LAST_ST : 0;
    else nx = m_st + 1;
    @(posedge clk_i);
    m_st = nx;
    m_q.push_back(gs);
    void'(m_q.pop_front());
    m_cyc++;
    @(negedge clk_i);
  endtask

  task automatic run(input int n, input bit gs, input bit fs, input bit fb,
                     input bit bi, input bit me, input string tag);
    for (int i = 0; i < n; i++) step(gs, fs, fb, bi, me, tag);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk_i);
    do_reset("R1");
    // R2: startup window, stop early, force overlaps
    run(4, 0, 0, 0, 1, 1, "R2");
    run(10, 1, 0, 0, 1, 1, "R2");
    run(2, 1, 1, 0, 1, 1, "R2 R8");
    run(4, 1, 0, 0, 1, 1, "R2");
    // R3 arm, R4 wait for idle busy
    run(4, 1, 0, 0, 0, 1, "R3 R4");
    run(1, 1, 0, 0, 1, 1, "R4");
    // R5 hold runs despite stop low, mask off, busy low; R6 exits at once
    run(3, 0, 0, 0, 0, 0, "R5");
    run(8, 0, 0, 0, 1, 1, "R5 R6");
    run(8, 0, 0, 0, 1, 1, "R10");
    // R6 stop held across wait state
    run(16, 1, 0, 0, 1, 1, "R6");
    run(12, 0, 0, 0, 1, 1, "R6 R10");
    // R7 bypass
    run(3, 1, 0, 0, 0, 0, "R7");
    run(4, 1, 0, 0, 1, 0, "R7");
    run(8, 0, 0, 0, 1, 0, "R7");
    // R10 forced bus busy and force stop alone
    run(4, 0, 0, 1, 1, 1, "R10");
    run(1, 0, 1, 0, 1, 1, "R8 R10");
    run(8, 0, 0, 0, 1, 1, "R10");
    // random mix
    begin
      bit gs = 0, bi = 1, me = 1;
      for (int i = 0; i < 3000; i++) begin
        if ($urandom_range(0, 9) == 0) gs = ~gs;
        if ($urandom_range(0, 3) == 0) bi = ~bi;
        if ($urandom_range(0, 49) == 0) me = ~me;
        step(gs, ($urandom_range(0, 39) == 0), ($urandom_range(0, 39) == 0), bi, me,
             "R3 R4 R5 R6 R7 R8 R9 R10");
      end
    end
    // R1 reset from a busy state
    run(12, 1, 0, 0, 1, 1, "R3");
    do_reset("R1");
    run(25, 1, 0, 0, 1, 1, "R2 R3");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired cyc=%0d got=running exp=done", m_cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule